// File: doc/BRIEF.md
# Horizontal Line Timing Sequencer

This block produces the per-line horizontal timing of a simple LCD display controller. A pixel-clock counter starts every line at zero and counts up to a programmed line total. It then wraps and raises a one-cycle end-of-line strobe. Software programs a set of absolute thresholds. When the counter equals a threshold, the controller latches a new line phase: sync, back porch, left border, active image, right border or front porch. The latched phase drives the sync pulse, the blank flag, the border-colour select and the pixel request strobe that a pixel fetch unit downstream consumes.

Software writes the thresholds, the line total and the border colour through a small write port into shadow registers. The whole set moves into the working copy at the wrap from the last count of a line to count zero. A phase plan therefore never changes part-way through a line. When two thresholds land on the same count, a fixed priority picks the phase. Some degenerate settings, such as a back-porch count that does not exceed the sync count, collapse phases in a defined way.

Top module: `hts_top`

## Requirements
- R1: While reset is high, the counter is held at zero and the line phase is front porch: hsync=0, blank=1, border_sel=0, pix_req=0 and eol=0. The default line total is all ones.
- R2: The counter counts 0,1,…,T and then returns to 0, where T is the active line total, so a line lasts T+1 cycles. eol is high exactly in the cycle where the count equals T.
- R3: A threshold event at count c changes the outputs from the cycle with count c+1 onward. The phase then holds until the next event, including across the line wrap.
- R4: Output decode of the phase: hsync=1 only in sync; blank=1 in sync, back porch and front porch; border_sel=1 in left and right border; pix_req=1 only in active image. Exactly one of blank, border_sel and pix_req is high.
- R5: The sync event fires only if the sync count is strictly below the back-porch count. Otherwise hsync stays low for the whole line. The back-porch event always takes the phase out of sync.
- R6: If the left-border count is at or below the back-porch count, the back-porch event goes straight to left border, so no blank back-porch cycle occurs. In that case the left-border event itself does nothing.
- R7: The image window register (address 3) holds the image-start count in bits [15:0] and the image-end count in bits [31:16]. Image start enters active image, and image end enters right border.
- R8: Events on the same count resolve in this priority, highest first: back porch, sync, image end, image start, left border, front porch. Image end equal to image start therefore gives no pix_req cycle.
- R9: Writes land in shadow registers. The whole set loads into the working copy only on the cycle after eol, so the rest of a line runs on the values it started with.
- R10: border_rgb always shows the active border colour (address 6, low COLOR_W bits). It is double-buffered like the thresholds.
- R11: Register addresses: 0 sync, 1 back porch, 2 left border, 3 image window, 4 front porch, 5 line total, 6 border colour. Thresholds use the low CNT_W bits of the written word. A write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync pulse |
| blank | output | 1 | No pixels and no border this cycle |
| border_sel | output | 1 | Border colour is on the display |
| pix_req | output | 1 | Active-image pixel request |
| border_rgb | output | COLOR_W | Active border colour |
| eol | output | 1 | Last count of the line |

## Verification
The bench builds the block with CNT_W=8 and COLOR_W=12. This keeps lines to a few dozen cycles, so every cycle of every line checked can be compared against an arithmetic phase model. With lines this short, the bench sweeps 128 threshold combinations. These place back porch below, equal to and above sync, and left border at, below and above back porch. They also cover image start equal to image end, and front porch equal to image end. This drives every equal-count priority case and the collapsed-phase rules, then a mid-line write and a write to the unused address.

// File: rtl/hts_pkg.sv
package hts_pkg;

    typedef enum logic [2:0] {
        PH_FRONT  = 3'd0,
        PH_SYNC   = 3'd1,
        PH_BACK   = 3'd2,
        PH_LEFT   = 3'd3,
        PH_IMAGE  = 3'd4,
        PH_RIGHT  = 3'd5
    } phase_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_SYNC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_BACK  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LEFT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_IMGW  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FRONT = 3'd4;
    localparam logic [ADDR_W-1:0] A_TOTAL = 3'd5;
    localparam logic [ADDR_W-1:0] A_COLOR = 3'd6;

    // Threshold slot indices in the register bank
    localparam int S_SYNC  = 0;
    localparam int S_BACK  = 1;
    localparam int S_LEFT  = 2;
    localparam int S_ISTA  = 3;
    localparam int S_IEND  = 4;
    localparam int S_FRONT = 5;
    localparam int S_TOTAL = 6;
    localparam int N_SLOT  = 7;

    function automatic logic phase_blank(phase_e p);
        return (p == PH_FRONT) || (p == PH_SYNC) || (p == PH_BACK);
    endfunction

    function automatic logic phase_border(phase_e p);
        return (p == PH_LEFT) || (p == PH_RIGHT);
    endfunction

endpackage

// File: rtl/hts_regs.sv
module hts_regs
    import hts_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int COLOR_W = 24,
    parameter int REG_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                line_wrap,
    output logic [CNT_W-1:0]    act_slot [N_SLOT],
    output logic [COLOR_W-1:0]  act_color
);
    localparam int HALF = REG_W / 2;

    logic [CNT_W-1:0]   shd_slot [N_SLOT];
    logic [COLOR_W-1:0] shd_color;
    logic [N_SLOT-1:0]  slot_we;
    logic [CNT_W-1:0]   slot_wd [N_SLOT];

    // Per-slot write decode; the image window feeds two slots
    generate
        for (genvar s = 0; s < N_SLOT; s++) begin : g_dec
            if (s == S_ISTA) begin : g_lo
                assign slot_we[s] = wr_en && (wr_addr == A_IMGW);
                assign slot_wd[s] = wr_data[CNT_W-1:0];
            end else if (s == S_IEND) begin : g_hi
                assign slot_we[s] = wr_en && (wr_addr == A_IMGW);
                assign slot_wd[s] = wr_data[HALF +: CNT_W];
            end else begin : g_plain
                localparam logic [ADDR_W-1:0] MY_ADDR =
                    (s == S_SYNC)  ? A_SYNC  :
                    (s == S_BACK)  ? A_BACK  :
                    (s == S_LEFT)  ? A_LEFT  :
                    (s == S_FRONT) ? A_FRONT : A_TOTAL;
                assign slot_we[s] = wr_en && (wr_addr == MY_ADDR);
                assign slot_wd[s] = wr_data[CNT_W-1:0];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    shd_slot[s] <= (s == S_TOTAL) ? '1 : '0;
                    act_slot[s] <= (s == S_TOTAL) ? '1 : '0;
                end else begin
                    if (slot_we[s]) shd_slot[s] <= slot_wd[s];
                    if (line_wrap)  act_slot[s] <= shd_slot[s];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_color <= '0;
            act_color <= '0;
        end else begin
            if (wr_en && (wr_addr == A_COLOR)) shd_color <= wr_data[COLOR_W-1:0];
            if (line_wrap) act_color <= shd_color;
        end
    end

endmodule

// File: rtl/hts_counter.sv
module hts_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = (cnt == total);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/hts_event.sv
module hts_event
    import hts_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] thr [N_SLOT],
    output logic             hit,
    output phase_e           next_ph
);
    logic at_sync, at_back, at_left, at_ista, at_iend, at_front;
    logic sync_ok, left_folds;

    assign at_sync    = (cnt == thr[S_SYNC]);
    assign at_back    = (cnt == thr[S_BACK]);
    assign at_left    = (cnt == thr[S_LEFT]);
    assign at_ista    = (cnt == thr[S_ISTA]);
    assign at_iend    = (cnt == thr[S_IEND]);
    assign at_front   = (cnt == thr[S_FRONT]);
    assign sync_ok    = (thr[S_SYNC] < thr[S_BACK]);
    assign left_folds = (thr[S_LEFT] <= thr[S_BACK]);

    always_comb begin
        hit     = 1'b1;
        next_ph = PH_FRONT;
        if (at_back)                    next_ph = left_folds ? PH_LEFT : PH_BACK;
        else if (at_sync && sync_ok)    next_ph = PH_SYNC;
        else if (at_iend)               next_ph = PH_RIGHT;
        else if (at_ista)               next_ph = PH_IMAGE;
        else if (at_left && !left_folds) next_ph = PH_LEFT;
        else if (at_front)              next_ph = PH_FRONT;
        else                            hit = 1'b0;
    end

endmodule

// File: rtl/hts_top.sv
module hts_top
    import hts_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int COLOR_W = 24,
    parameter int REG_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [31:0]        wr_data,
    output logic               hsync,
    output logic               blank,
    output logic               border_sel,
    output logic               pix_req,
    output logic [COLOR_W-1:0] border_rgb,
    output logic               eol
);
    logic [CNT_W-1:0]   act_slot [N_SLOT];
    logic [COLOR_W-1:0] act_color;
    logic [CNT_W-1:0]   cnt;
    logic               wrap;
    logic               ev_hit;
    phase_e             ev_ph;
    phase_e             phase_q;

    hts_regs #(.CNT_W(CNT_W), .COLOR_W(COLOR_W), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .line_wrap (wrap),
        .act_slot  (act_slot),
        .act_color (act_color)
    );

    hts_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .total (act_slot[S_TOTAL]),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    hts_event #(.CNT_W(CNT_W)) u_evt (
        .cnt     (cnt),
        .thr     (act_slot),
        .hit     (ev_hit),
        .next_ph (ev_ph)
    );

    always_ff @(posedge clk) begin
        if (rst)         phase_q <= PH_FRONT;
        else if (ev_hit) phase_q <= ev_ph;
    end

    assign hsync      = (phase_q == PH_SYNC);
    assign blank      = phase_blank(phase_q);
    assign border_sel = phase_border(phase_q);
    assign pix_req    = (phase_q == PH_IMAGE);
    assign border_rgb = act_color;
    assign eol        = wrap && !rst;

endmodule

// File: rtl/hts_chk.sv
module hts_chk #(
    parameter int CNT_W   = 16,
    parameter int COLOR_W = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               hsync,
    input logic               blank,
    input logic               border_sel,
    input logic               pix_req,
    input logic               eol,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   thr_sync,
    input logic [CNT_W-1:0]   thr_back,
    input logic [CNT_W-1:0]   thr_ista,
    input logic [CNT_W-1:0]   thr_total,
    input logic [COLOR_W-1:0] border_rgb
);
    // R4: one class of output per cycle
    p_one_class_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({blank, border_sel, pix_req}) == 1);

    // R4: sync is a blank phase
    p_sync_blank_r4: assert property (@(posedge clk) disable iff (rst)
        hsync |-> blank);

    // R2: the count returns to zero after the end-of-line cycle
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
        eol |=> (cnt == '0));

    // R3, R5: sync starts one cycle after the sync count, only if below back porch
    p_sync_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> ($past(cnt) == $past(thr_sync) && $past(thr_sync) < $past(thr_back)));

    // R7: image phase begins one cycle after the image-start count
    p_img_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_req) |-> ($past(cnt) == $past(thr_ista)));

    // R9, R10: working copy only moves at the line wrap
    p_hold_midline_r9: assert property (@(posedge clk) disable iff (rst)
        !eol |=> ($stable(thr_sync) && $stable(thr_back) && $stable(thr_total) && $stable(border_rgb)));

endmodule

bind hts_top hts_chk #(.CNT_W(CNT_W), .COLOR_W(COLOR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hsync      (hsync),
    .blank      (blank),
    .border_sel (border_sel),
    .pix_req    (pix_req),
    .eol        (eol),
    .cnt        (cnt),
    .thr_sync   (act_slot[0]),
    .thr_back   (act_slot[1]),
    .thr_ista   (act_slot[3]),
    .thr_total  (act_slot[6]),
    .border_rgb (border_rgb)
);

// File: tb/tb_hts_top.sv
module tb_hts_top;
    localparam int CNT_W   = 8;
    localparam int COLOR_W = 12;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [2:0]         wr_addr = '0;
    logic [31:0]        wr_data = '0;
    logic               hsync, blank, border_sel, pix_req, eol;
    logic [COLOR_W-1:0] border_rgb;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench phase codes: 0 front, 1 sync, 2 back, 3 left, 4 image, 5 right
    int sy, bp, lb, ist, ien, fp, tot;
    logic [COLOR_W-1:0] col;

    always #4 clk = ~clk;

    hts_top #(.CNT_W(CNT_W), .COLOR_W(COLOR_W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .blank(blank), .border_sel(border_sel), .pix_req(pix_req),
        .border_rgb(border_rgb), .eol(eol)
    );

    // Phase after an event at count c, given phase m (R3, R5, R6, R7, R8)
    function automatic int step(int m, int c);
        if (c == bp)                  return (lb <= bp) ? 3 : 2;
        if (c == sy && sy < bp)       return 1;
        if (c == ien)                 return 5;
        if (c == ist)                 return 4;
        if (c == lb && lb > bp)       return 3;
        if (c == fp)                  return 0;
        return m;
    endfunction

    task automatic put(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_all();
        put(3'd0, 32'(sy));
        put(3'd1, 32'(bp));
        put(3'd2, 32'(lb));
        put(3'd3, {16'(ien), 16'(ist)});   // R7: start low half, end high half
        put(3'd4, 32'(fp));
        put(3'd5, 32'(tot));
        put(3'd6, 32'(col));
    endtask

    task automatic cmp(input int m, input int c, input string tag);
        logic e_hs, e_bl, e_bo, e_px, e_eol;
        e_hs  = (m == 1);
        e_bl  = (m <= 2);
        e_bo  = (m == 3) || (m == 5);
        e_px  = (m == 4);
        e_eol = (c == tot);
        n_vec++;
        if (hsync !== e_hs) begin
            n_bad++; $display("FAIL R5 %s count %0d hsync=%b expected %b", tag, c, hsync, e_hs);
        end else if ({blank, border_sel, pix_req} !== {e_bl, e_bo, e_px}) begin
            n_bad++; $display("FAIL R4 %s count %0d blank/border/pix=%b expected %b",
                              tag, c, {blank, border_sel, pix_req}, {e_bl, e_bo, e_px});
        end else if (eol !== e_eol) begin
            n_bad++; $display("FAIL R2 %s count %0d eol=%b expected %b", tag, c, eol, e_eol);
        end else if (border_rgb !== col) begin
            n_bad++; $display("FAIL R10 %s count %0d border_rgb=%h expected %h", tag, c, border_rgb, col);
        end
    endtask

    // Wait for a wrap (loads config), skip one line, check the next line cycle by cycle.
    // With mid_wr set, a colour write lands at count 3 and must not affect this line (R9).
    task automatic check_line(input string tag, input bit mid_wr, input logic [COLOR_W-1:0] mid_col);
        int m;
        do @(negedge clk); while (!eol && !done);
        for (int c = 0; c <= tot; c++) @(negedge clk);
        m = 0;
        for (int c = 0; c <= tot; c++) m = step(m, c);
        for (int c = 0; c <= tot; c++) begin
            @(negedge clk);
            if (done) return;
            cmp(m, c, tag);
            if (mid_wr && c == 3) begin
                wr_en = 1'b1; wr_addr = 3'd6; wr_data = 32'(mid_col);
            end else begin
                wr_en = 1'b0;
            end
            m = step(m, c);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int idx;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            n_vec++;
            if ({hsync, blank, border_sel, pix_req, eol} !== 5'b01000) begin
                n_bad++;
                $display("FAIL R1 reset outputs=%b expected 01000", {hsync, blank, border_sel, pix_req, eol});
            end
        end
        rst = 1'b0;

        // Sweep: R3 R5 R6 R7 R8 R11 over equal and crossed thresholds
        sy = 4;
        idx = 0;
        for (int bi = 0; bi < 4; bi++)
            for (int li = 0; li < 4; li++)
                for (int si = 0; si < 2; si++)
                    for (int ei = 0; ei < 2; ei++)
                        for (int fi = 0; fi < 2; fi++) begin
                            bp  = (bi == 0) ? 3 : (bi == 1) ? 4 : (bi == 2) ? 5 : 20;
                            lb  = (li == 0) ? 0 : (li == 1) ? bp - 1 : (li == 2) ? bp : bp + 2;
                            ist = ((lb > bp) ? lb : bp) + 3 * si;
                            ien = ist + 5 * ei;
                            fp  = ien + 2 * fi;
                            tot = fp + 8;
                            col = 12'hA00 + 12'(idx);
                            idx++;
                            if (!done) begin
                                program_all();
                                check_line("sweep", 1'b0, '0);
                            end
                        end

        // R9: a mid-line colour write leaves the current line alone, then applies
        sy = 6; bp = 24; lb = 26; ist = 30; ien = 60; fp = 62; tot = 140; col = 12'h123;
        if (!done) program_all();
        if (!done) check_line("R9 before", 1'b1, 12'h456);
        col = 12'h456;
        if (!done) check_line("R9 after", 1'b0, '0);

        // R11: address 7 writes change nothing
        if (!done) put(3'd7, 32'hFFFF_FFFF);
        if (!done) check_line("R11 unused", 1'b0, '0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule